// File: doc/BRIEF.md
# Single-Slope PWM Timer with Buffered Updates

This block is an up-counting timer that produces pulse-width modulated outputs on a set of compare channels. On every cycle in which the tick enable is high and the timer is running, the counter advances by one. When it has reached the active period value it returns to zero, so one PWM cycle lasts period + 1 ticks. For example, a 48 MHz tick with a period of 1919 gives a 25 kHz PWM rate.

Each channel compares the count with its own compare value, and a polarity bit can invert the result. An inverted channel gives the complementary waveform, which after low-pass filtering is the same signal shifted by 180 degrees. The period and the compare values can be written directly, and a direct write takes effect at once. They can also be written through buffers, which load only at the wrap, so a duty or period change never cuts a PWM cycle short.

Each wrap produces three things: a one-cycle event pulse for an external sequencer such as a DMA engine, a sticky flag that software clears by writing a one to it, and an interrupt that is gated by an enable bit.

Top module: `pwm_slope_timer`

## Requirements
- R1: The counter advances only on cycles with `tick_en` high while running. After reaching the active period P it returns to 0, so `ovf_pulse` repeats every P+1 ticks.
- R2: After reset:
  - the count reads 0;
  - the active period reads all ones;
  - the compare values, control register and flag read 0;
  - `pwm_out`, `irq` and `ovf_pulse` are low.
- R3: Before polarity is applied, channel n is high while the count is below its active compare value C, so it is high for C of the P+1 counts. C=0 gives a constant low and C=P+1 a constant high.
- R4: When the channel's polarity bit (control bit 2+n) is set, the channel output is inverted, giving high for P+1-C counts.
- R5: A write to address 3 (period buffer) loads the active period only at the next wrap, and the running cycle keeps its length. A write to address 2 changes the active period in the next cycle. Reading address 2 returns the active period.
- R6: A write to address 8+n (compare buffer n) reaches the active compare n only at the next wrap. Address 4+n writes and reads the active compare n directly.
- R7: `ovf_pulse` is high for exactly one clock after each wrap, in the cycle in which the count reads 0.
- R8: The flag (address 1, bit 0) is set at every wrap. Writing 1 to it clears it, and writing 0 to it leaves it unchanged.
- R9: `irq` is high when the flag is set and the interrupt enable (control bit 1) is set. It is low when either of the two is clear.
- R10: When the run bit (control bit 0) is clear, the count holds at 0 (address 12 reads 0) and each output drives its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable (tick) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | CNT_W | Read data, combinational |
| pwm_out | output | NUM_CH | Channel outputs after polarity |
| ovf_pulse | output | 1 | One-cycle wrap event |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions check the following on every cycle:
- the event pulse lands on count zero;
- the flag is set whenever the pulse fires;
- a stopped timer holds zero and drives its polarity levels;
- the active period changes only at a wrap or after a direct write.

Only the directed scenarios can show the timing properties:
- the period length under full-rate and half-rate ticks;
- the duty cycle per channel at the edge values 0, P and P+1;
- that a buffered write leaves the cycle in progress untouched and rules the following one;
- the write-one-to-clear behaviour together with the interrupt gating.

// File: rtl/pwm_slope_pkg.sv
package pwm_slope_pkg;
   localparam int REG_AW = 4;
   localparam int MAX_CH = 4;
   // register addresses
   localparam logic [REG_AW-1:0] A_CTRL  = 4'd0;
   localparam logic [REG_AW-1:0] A_FLAG  = 4'd1;
   localparam logic [REG_AW-1:0] A_PER   = 4'd2;
   localparam logic [REG_AW-1:0] A_PERB  = 4'd3;
   localparam logic [REG_AW-1:0] A_CMP0  = 4'd4;
   localparam logic [REG_AW-1:0] A_CMPB0 = 4'd8;
   localparam logic [REG_AW-1:0] A_CNT   = 4'd12;
   // control bit positions
   localparam int C_RUN  = 0;
   localparam int C_IE   = 1;
   localparam int C_POL0 = 2;
endpackage

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick_en,
   input  logic [CNT_W-1:0] per_act,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap,
   output logic             ovf_pulse
);
   // A period lowered below the count by a direct write still wraps.
   assign wrap = run && tick_en && (cnt_q >= per_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         ovf_pulse <= 1'b0;
      end else begin
         ovf_pulse <= wrap;
         if (!run)
            cnt_q <= '0;
         else if (tick_en)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
   import pwm_slope_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_CH  = 4,
   parameter logic [CNT_W-1:0] PER_RST = '1,
   localparam int CTL_W  = 2 + NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              wrap,
   output logic [CTL_W-1:0]  ctrl_q,
   output logic              run,
   output logic              irq_en,
   output logic [NUM_CH-1:0] pol,
   output logic [CNT_W-1:0]  per_act,
   output logic [CNT_W-1:0]  per_buf,
   output logic              flag,
   output logic              irq
);
   logic per_pend;
   logic wr_ctrl, wr_flag, wr_per, wr_perb;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign wr_flag = wr_en && (wr_addr == A_FLAG);
   assign wr_per  = wr_en && (wr_addr == A_PER);
   assign wr_perb = wr_en && (wr_addr == A_PERB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag   <= 1'b0;
      end else begin
         if (wr_ctrl)
            ctrl_q <= wr_data[CTL_W-1:0];
         // a wrap in the same cycle as a clear keeps the flag set
         if (wrap)
            flag <= 1'b1;
         else if (wr_flag && wr_data[0])
            flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_act  <= PER_RST;
         per_buf  <= PER_RST;
         per_pend <= 1'b0;
      end else begin
         if (wr_per) begin
            per_act  <= wr_data;
            per_pend <= 1'b0;
         end else if (wrap && per_pend) begin
            per_act  <= per_buf;
            per_pend <= 1'b0;
         end
         if (wr_perb) begin
            per_buf  <= wr_data;
            per_pend <= 1'b1;
         end
      end
   end

   assign run    = ctrl_q[C_RUN];
   assign irq_en = ctrl_q[C_IE];
   assign pol    = ctrl_q[C_POL0 +: NUM_CH];
   assign irq    = flag && irq_en;
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pol,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wrap,
   input  logic             cmp_wr,
   input  logic             cmpb_wr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cmp_act,
   output logic [CNT_W-1:0] cmp_buf,
   output logic             pwm_o
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_act <= '0;
         cmp_buf <= '0;
         pend    <= 1'b0;
      end else begin
         if (cmp_wr) begin
            cmp_act <= wr_data;
            pend    <= 1'b0;
         end else if (wrap && pend) begin
            cmp_act <= cmp_buf;
            pend    <= 1'b0;
         end
         if (cmpb_wr) begin
            cmp_buf <= wr_data;
            pend    <= 1'b1;
         end
      end
   end

   assign pwm_o = (run && (cnt < cmp_act)) ^ pol;
endmodule

// File: rtl/pwm_slope_timer.sv
module pwm_slope_timer
   import pwm_slope_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 4,
   parameter logic [CNT_W-1:0] PER_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic [NUM_CH-1:0] pwm_out,
   output logic              ovf_pulse,
   output logic              irq
);
   localparam int CTL_W = 2 + NUM_CH;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("pwm_slope_timer: NUM_CH must be 1..%0d", MAX_CH);
   end
   if (CNT_W < CTL_W) begin : g_bad_w
      $error("pwm_slope_timer: CNT_W too narrow for control register");
   end

   logic [CTL_W-1:0]  ctrl_q;
   logic              run, irq_en, flag, wrap;
   logic [NUM_CH-1:0] pol;
   logic [CNT_W-1:0]  per_act, per_buf, cnt_q;
   logic [CNT_W-1:0]  cmp_act [NUM_CH];
   logic [CNT_W-1:0]  cmp_buf [NUM_CH];

   pwm_ctrl_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .PER_RST(PER_RST)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wrap(wrap), .ctrl_q(ctrl_q), .run(run),
      .irq_en(irq_en), .pol(pol), .per_act(per_act), .per_buf(per_buf),
      .flag(flag), .irq(irq)
   );

   pwm_period_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
      .per_act(per_act), .cnt_q(cnt_q), .wrap(wrap), .ovf_pulse(ovf_pulse)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic cmp_wr, cmpb_wr;
      assign cmp_wr  = wr_en && (wr_addr == A_CMP0  + REG_AW'(i));
      assign cmpb_wr = wr_en && (wr_addr == A_CMPB0 + REG_AW'(i));
      pwm_cmp_chan #(.CNT_W(CNT_W)) chan_i (
         .clk(clk), .rst_n(rst_n), .run(run), .pol(pol[i]), .cnt(cnt_q),
         .wrap(wrap), .cmp_wr(cmp_wr), .cmpb_wr(cmpb_wr), .wr_data(wr_data),
         .cmp_act(cmp_act[i]), .cmp_buf(cmp_buf[i]), .pwm_o(pwm_out[i])
      );
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL)      rd_data = CNT_W'(ctrl_q);
      else if (rd_addr == A_FLAG) rd_data = CNT_W'(flag);
      else if (rd_addr == A_PER)  rd_data = per_act;
      else if (rd_addr == A_PERB) rd_data = per_buf;
      else if (rd_addr == A_CNT)  rd_data = cnt_q;
      else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == A_CMP0 + REG_AW'(i))  rd_data = cmp_act[i];
            if (rd_addr == A_CMPB0 + REG_AW'(i)) rd_data = cmp_buf[i];
         end
      end
   end
endmodule

// File: rtl/pwm_slope_timer_chk.sv
module pwm_slope_timer_chk
   import pwm_slope_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] wr_addr,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  per_act,
   input logic              run,
   input logic [NUM_CH-1:0] pol,
   input logic              flag,
   input logic              irq_en,
   input logic              irq,
   input logic              ovf_pulse,
   input logic [NUM_CH-1:0] pwm_out
);
   // R7
   ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> cnt_q == '0);

   // R10
   idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == '0);

   // R10
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> pwm_out == pol);

   // R8
   ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> flag);

   // R9
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag) && irq_en) |-> irq);

   // R5
   per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_pulse && !($past(wr_en) && $past(wr_addr) == A_PER)) |-> $stable(per_act));
endmodule

bind pwm_slope_timer pwm_slope_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .cnt_q(cnt_q),
   .per_act(per_act), .run(run), .pol(pol), .flag(flag), .irq_en(irq_en),
   .irq(irq), .ovf_pulse(ovf_pulse), .pwm_out(pwm_out)
);

// File: tb/pwm_slope_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_slope_timer_tb_top;
   localparam int W = 16;
   localparam int N = 4;
   localparam logic [3:0] AD_CTRL = 4'd0, AD_FLAG = 4'd1, AD_PER = 4'd2,
                          AD_PERB = 4'd3, AD_CMP = 4'd4, AD_CMPB = 4'd8, AD_CNT = 4'd12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b1;
   logic half = 1'b0;
   logic wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [W-1:0] rd_data;
   logic [N-1:0] pwm_out;
   logic ovf_pulse, irq;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;
   always @(negedge clk) tick_en <= half ? ~tick_en : 1'b1;

   pwm_slope_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .pwm_out(pwm_out), .ovf_pulse(ovf_pulse), .irq(irq)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output longint v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic wait_pulse();
      @(negedge clk);
      while (!ovf_pulse) @(negedge clk);
   endtask

   task automatic interval(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!ovf_pulse);
   endtask

   function automatic logic [W-1:0] ctl(input bit r, input bit ie, input logic [N-1:0] p);
      return W'({p, ie, r});
   endfunction

   task automatic t_reset();
      longint v;
      rd(AD_CNT, v);  chk("R2 count", v, 0);
      rd(AD_PER, v);  chk("R2 period", v, 65535);
      rd(AD_CTRL, v); chk("R2 control", v, 0);
      rd(AD_FLAG, v); chk("R2 flag", v, 0);
      rd(AD_CMP, v);  chk("R2 compare0", v, 0);
      chk("R2 outputs", pwm_out, 0);
      chk("R2 irq", irq, 0);
      chk("R2 ovf_pulse", ovf_pulse, 0);
   endtask

   task automatic t_period();
      int n; longint v;
      wr(AD_PER, 9);
      wr(AD_CMP + 0, 4); wr(AD_CMP + 1, 0); wr(AD_CMP + 2, 10); wr(AD_CMP + 3, 9);
      wr(AD_CTRL, ctl(1, 0, 4'b0000));
      wait_pulse();
      rd(AD_CNT, v); chk("R7 count at pulse", v, 0);
      @(negedge clk);
      chk("R7 pulse width", ovf_pulse, 0);
      wait_pulse(); interval(n); chk("R1 full-rate interval", n, 10);
      half = 1'b1;
      wait_pulse(); interval(n); chk("R1 half-rate interval", n, 20);
      half = 1'b0;
      wait_pulse();
   endtask

   task automatic t_duty();
      int h [N];
      wait_pulse();
      for (int c = 0; c < N; c++) h[c] = int'(pwm_out[c]);
      for (int k = 1; k < 10; k++) begin
         @(negedge clk);
         for (int c = 0; c < N; c++) h[c] += int'(pwm_out[c]);
      end
      chk("R3 cmp=4", h[0], 4);
      chk("R3 cmp=0", h[1], 0);
      chk("R3 cmp=P+1", h[2], 10);
      chk("R3 cmp=P", h[3], 9);
   endtask

   task automatic t_pol();
      int h;
      wr(AD_CTRL, ctl(1, 0, 4'b0001));
      wait_pulse();
      h = int'(pwm_out[0]);
      for (int k = 1; k < 10; k++) begin @(negedge clk); h += int'(pwm_out[0]); end
      chk("R4 inverted high count", h, 6);
      wr(AD_CTRL, ctl(1, 0, 4'b0000));
   endtask

   task automatic t_perbuf();
      int n; longint v;
      wait_pulse();
      wr_en = 1'b1; wr_addr = AD_PERB; wr_data = 4;
      @(negedge clk); wr_en = 1'b0; n = 1;
      rd(AD_PER, v); chk("R5 active period before wrap", v, 9);
      while (!ovf_pulse) begin @(negedge clk); n++; end
      chk("R5 running cycle length kept", n, 10);
      rd(AD_PER, v); chk("R5 period loaded at wrap", v, 4);
      interval(n); chk("R5 new interval", n, 5);
      wr(AD_PER, 9);
      rd(AD_PER, v); chk("R5 direct period write", v, 9);
      wait_pulse();
   endtask

   task automatic t_cmpbuf();
      int h; longint v;
      wait_pulse();
      wr_en = 1'b1; wr_addr = AD_CMPB; wr_data = 7;
      h = 0;
      do begin
         @(negedge clk); wr_en = 1'b0;
         if (!ovf_pulse) h += int'(pwm_out[0]);
      end while (!ovf_pulse);
      chk("R6 old compare until wrap", h, 3);
      rd(AD_CMP, v); chk("R6 active compare loaded", v, 7);
      h = int'(pwm_out[0]);
      for (int k = 1; k < 10; k++) begin @(negedge clk); h += int'(pwm_out[0]); end
      chk("R6 new duty", h, 7);
   endtask

   task automatic t_flag();
      longint v;
      wait_pulse();
      rd(AD_FLAG, v); chk("R8 flag set at wrap", v, 1);
      chk("R9 irq masked", irq, 0);
      wr(AD_CTRL, ctl(0, 0, 4'b0000));
      @(negedge clk);
      rd(AD_CNT, v); chk("R10 count held", v, 0);
      chk("R10 idle outputs low", pwm_out, 0);
      wr(AD_CTRL, ctl(0, 0, 4'b1010));
      chk("R10 idle outputs follow polarity", pwm_out, 4'b1010);
      wr(AD_FLAG, 0);
      rd(AD_FLAG, v); chk("R8 write zero keeps flag", v, 1);
      wr(AD_CTRL, ctl(0, 1, 4'b0000));
      chk("R9 irq enabled", irq, 1);
      wr(AD_FLAG, 1);
      rd(AD_FLAG, v); chk("R8 write one clears", v, 0);
      chk("R9 irq after clear", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_period();
      t_duty();
      t_pol();
      t_perbuf();
      t_cmpbuf();
      t_flag();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule